// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block holds the programmable state of a four-channel DMA controller and presents it on an 8-bit I/O bus with a 4-bit port offset. Offsets 0 to 7 reach the per-channel 16-bit base address and base count registers, one byte at a time. A single byte pointer, shared by all channels, selects whether an access hits the low or the high byte. Offsets 8 to 15 reach the control functions: command, software request, single and whole mask updates, mode, pointer clear and master reset. Status and mask can be read back from this range.

A transfer engine sits beside the block. It reports how far each channel has progressed through a progress value and a per-channel load strobe, and it reports terminal counts on a per-channel pulse. Address and count readback are derived from the base registers and the progress value. The block does not keep a separately decremented counter. A parameter selects byte-addressed operation (shift 0) or word-addressed operation (shift 1). It sets how far the base address is shifted into the current address and which bits of the derived values a byte read returns.

Top module: `dma4_regfile`

## Requirements
- R1: After hardware reset every mask bit is 1, the command byte and the status byte are 0, all channel registers are 0 and the byte pointer selects the low byte.
- R2: A single byte pointer serves all channel ports (offsets 0 to 7). Every read or write there uses the pointer (0 = low byte, 1 = high byte) and then inverts it. A write to offset 12 clears the pointer. Reads of control offsets do not move it.
- R3: At a channel port, offset bits 2:1 give the channel and bit 0 selects the address register (0) or the count register (1). Writing a high byte reloads that channel's current address with its base address shifted left by the word shift.
- R4: A count-port read returns a byte of (base count << shift) − progress. An address-port read returns a byte of current address + progress, or current address − progress when mode bit 5 is 1. The byte returned is the value shifted right by shift + 8·pointer, and it appears on io_rdata in the cycle after the read.
- R5: Writing offset 8 loads the command byte when the data is 0 or has no bit set other than bit 2. Any other value leaves the command byte unchanged.
- R6: Writing offset 9 sets or clears the request bit of channel data[1:0] (status bit 4+n) according to data bit 2. It also clears that channel's terminal-count bit (status bit n). req_o shows status bits 7:4.
- R7: Offset 10 sets or clears mask bit data[1:0] according to data bit 2. Offset 14 clears all mask bits. Offset 15 loads the mask from data[3:0]. Offset 11 stores data as the mode byte of channel data[1:0].
- R8: Writing offset 13 clears the byte pointer, the status and the command, and sets every mask bit.
- R9: Reading offset 8 returns the status and then clears status bits 3:0. Reading offset 15 returns the mask in bits 3:0. Reading any other control offset returns 0.
- R10: A pulse on tc_hit[n] sets status bit n. It takes effect even in a cycle that also clears bits 3:0 by a status read or by a request write.
- R11: A pulse on prog_load[n] stores prog_value as channel n's progress. A high-byte write to channel n clears the progress to 0, and this clear wins over a load of the same channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Bus access strobe |
| io_wr | input | 1 | Write access (wins if io_rd is also set) |
| io_rd | input | 1 | Read access |
| io_port | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| prog_load | input | 4 | Per-channel progress load strobe |
| prog_value | input | 16+WORD_SHIFT | Progress value from the transfer engine |
| tc_hit | input | 4 | Per-channel terminal-count pulse |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Request bits (status 7:4) |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| cur_addr_o | output | 4·(16+WORD_SHIFT) | Current address of each channel |
| base_cnt_o | output | 64 | Base count of each channel |

## Verification
Two pairs of events can collide in one cycle. The bench drives each pair on the same clock edge. In the first, a transfer-engine progress load lands together with a high-byte bus write to the same channel. The following count and address reads must show a progress of zero, so the count read returns the base count itself. In the second, a terminal-count pulse arrives during a status read. That read must return the old status, and the next read must show the new terminal-count bit, because the pulse is not lost to the read-clear.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = 2;
  localparam int BASE_W = 16;

  localparam logic [3:0] OFS_CMD    = 4'd8;
  localparam logic [3:0] OFS_REQ    = 4'd9;
  localparam logic [3:0] OFS_MASK1  = 4'd10;
  localparam logic [3:0] OFS_MODE   = 4'd11;
  localparam logic [3:0] OFS_PTRCLR = 4'd12;
  localparam logic [3:0] OFS_MRESET = 4'd13;
  localparam logic [3:0] OFS_MCLR   = 4'd14;
  localparam logic [3:0] OFS_MALL   = 4'd15;

  localparam int MODE_DEC_BIT = 5;

  // a command is accepted when it is zero or only uses bit 2
  function automatic logic cmd_supported(input logic [7:0] d);
    return (d & 8'hFB) == 8'h00;
  endfunction
endpackage

// File: rtl/dma4_byteptr.sv
module dma4_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic clear,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= 1'b0;
    else if (clear)  ptr <= 1'b0;
    else if (access) ptr <= ~ptr;
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    access && !clear |=> ptr != $past(ptr)); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ptr); // R2
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int CUR_W = BASE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             sel_cnt,
  input  logic [7:0]       wdata,
  input  logic             prog_ld,
  input  logic [CUR_W-1:0] prog_val,
  input  logic             dec,
  output logic [CUR_W-1:0] cur_addr,
  output logic [BASE_W-1:0] base_cnt,
  output logic [CUR_W-1:0] addr_view,
  output logic [CUR_W-1:0] cnt_view
);
  logic [BASE_W-1:0] base_addr;
  logic [CUR_W-1:0]  prog_q;
  logic [BASE_W-1:0] reload_base;
  logic              reload;

  function automatic logic [CUR_W-1:0] addr_calc(input logic [CUR_W-1:0] cur,
                                                 input logic [CUR_W-1:0] prog,
                                                 input logic down);
    return down ? cur - prog : cur + prog;
  endfunction

  function automatic logic [CUR_W-1:0] cnt_calc(input logic [BASE_W-1:0] cnt,
                                                input logic [CUR_W-1:0] prog);
    return (CUR_W'(cnt) << SHIFT) - prog;
  endfunction

  assign reload      = wr_hi;
  assign reload_base = sel_cnt ? base_addr : {wdata, base_addr[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog_q    <= '0;
    end else begin
      if (wr_lo) begin
        if (sel_cnt) base_cnt[7:0]  <= wdata;
        else         base_addr[7:0] <= wdata;
      end
      if (reload) begin
        if (sel_cnt) base_cnt[15:8]  <= wdata;
        else         base_addr[15:8] <= wdata;
        cur_addr <= CUR_W'(reload_base) << SHIFT;
        prog_q   <= '0;
      end else if (prog_ld) begin
        prog_q <= prog_val;
      end
    end
  end

  assign addr_view = addr_calc(cur_addr, prog_q, dec);
  assign cnt_view  = cnt_calc(base_cnt, prog_q);

  AST_RELOAD_CLEARS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_view == (CUR_W'(base_cnt) << SHIFT)); // R11
  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ld && !reload && !wr_lo |=> cnt_view == (CUR_W'(base_cnt) << SHIFT) - $past(prog_val)); // R11
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     ofs,
  input  logic [7:0]     wdata,
  input  logic           stat_rd,
  input  logic [NCH-1:0] tc_hit,
  output logic [7:0]     cmd,
  output logic [NCH-1:0] mask,
  output logic [2*NCH-1:0] status,
  output logic [8*NCH-1:0] mode_flat,
  output logic           ptr_clear
);
  logic [7:0]       mode_q [NCH];
  logic [2*NCH-1:0] status_nxt;
  logic [NCH-1:0]   mask_nxt;
  logic [CH_W-1:0]  ch;
  logic             master_rst;
  logic             cmd_reject;

  assign ch         = wdata[CH_W-1:0];
  assign master_rst = wr_en && ofs == OFS_MRESET;
  assign cmd_reject = wr_en && ofs == OFS_CMD && !cmd_supported(wdata);
  assign ptr_clear  = wr_en && (ofs == OFS_PTRCLR || ofs == OFS_MRESET);

  always_comb begin
    status_nxt = status;
    if (stat_rd) status_nxt[NCH-1:0] = '0;
    if (wr_en && ofs == OFS_REQ) begin
      status_nxt[NCH + int'(ch)] = wdata[2];
      status_nxt[int'(ch)]       = 1'b0;
    end
    if (master_rst) status_nxt = '0;
    status_nxt[NCH-1:0] = status_nxt[NCH-1:0] | tc_hit;
  end

  always_comb begin
    mask_nxt = mask;
    if (wr_en) begin
      unique case (ofs)
        OFS_MASK1:  mask_nxt[ch] = wdata[2];
        OFS_MRESET: mask_nxt = '1;
        OFS_MCLR:   mask_nxt = '0;
        OFS_MALL:   mask_nxt = wdata[NCH-1:0];
        default:    mask_nxt = mask;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= '0;
      mask   <= '1;
      status <= '0;
    end else begin
      mask   <= mask_nxt;
      status <= status_nxt;
      if (master_rst) cmd <= '0;
      else if (wr_en && ofs == OFS_CMD && cmd_supported(wdata)) cmd <= wdata;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[n] <= '0;
      else if (wr_en && ofs == OFS_MODE && int'(ch) == n) mode_q[n] <= wdata;
    end
    assign mode_flat[8*n +: 8] = mode_q[n];
  end

  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> $stable(cmd)); // R5
  AST_MASTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    master_rst |=> mask == '1 && cmd == '0); // R8
  AST_STAT_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && tc_hit == '0 |=> status[NCH-1:0] == '0); // R9
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit != '0 |=> (status[NCH-1:0] & $past(tc_hit)) == $past(tc_hit)); // R10
endmodule

// File: rtl/dma4_regfile.sv
module dma4_regfile
  import dma4_pkg::*;
#(
  parameter int WORD_SHIFT = 0,
  localparam int CUR_W = BASE_W + WORD_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_sel,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [3:0]            io_port,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  input  logic [NCH-1:0]        prog_load,
  input  logic [CUR_W-1:0]      prog_value,
  input  logic [NCH-1:0]        tc_hit,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH-1:0]        req_o,
  output logic [7:0]            cmd_o,
  output logic [8*NCH-1:0]      mode_o,
  output logic [NCH*CUR_W-1:0]  cur_addr_o,
  output logic [NCH*BASE_W-1:0] base_cnt_o
);
  logic             bus_wr, bus_rd, is_ch, is_cnt, ch_access;
  logic             ctrl_wr, stat_rd, ptr, ptr_clear;
  logic [CH_W-1:0]  ch_idx;
  logic [2*NCH-1:0] status;
  logic [CUR_W-1:0] addr_view [NCH];
  logic [CUR_W-1:0] cnt_view  [NCH];
  logic [7:0]       rdata_nxt;

  function automatic logic [7:0] pick_byte(input logic [CUR_W-1:0] v, input logic hi);
    logic [CUR_W-1:0] s;
    s = v >> (WORD_SHIFT + (hi ? 8 : 0));
    return s[7:0];
  endfunction

  assign bus_wr    = io_sel && io_wr;
  assign bus_rd    = io_sel && io_rd && !io_wr;
  assign is_ch     = !io_port[3];
  assign ch_idx    = io_port[CH_W:1];
  assign is_cnt    = io_port[0];
  assign ch_access = is_ch && (bus_wr || bus_rd);
  assign ctrl_wr   = bus_wr && !is_ch;
  assign stat_rd   = bus_rd && io_port == OFS_CMD;

  dma4_byteptr u_ptr (
    .clk(clk), .rst_n(rst_n), .access(ch_access), .clear(ptr_clear), .ptr(ptr)
  );

  dma4_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .ofs(io_port), .wdata(io_wdata),
    .stat_rd(stat_rd), .tc_hit(tc_hit), .cmd(cmd_o), .mask(mask_o),
    .status(status), .mode_flat(mode_o), .ptr_clear(ptr_clear)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = bus_wr && is_ch && int'(ch_idx) == n;
    dma4_chan #(.SHIFT(WORD_SHIFT)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(hit && !ptr), .wr_hi(hit && ptr), .sel_cnt(is_cnt),
      .wdata(io_wdata), .prog_ld(prog_load[n]), .prog_val(prog_value),
      .dec(mode_o[8*n + MODE_DEC_BIT]),
      .cur_addr(cur_addr_o[n*CUR_W +: CUR_W]),
      .base_cnt(base_cnt_o[n*BASE_W +: BASE_W]),
      .addr_view(addr_view[n]), .cnt_view(cnt_view[n])
    );
  end

  assign req_o = status[2*NCH-1:NCH];

  always_comb begin
    if (is_ch)
      rdata_nxt = pick_byte(is_cnt ? cnt_view[ch_idx] : addr_view[ch_idx], ptr);
    else if (io_port == OFS_CMD)
      rdata_nxt = status;
    else if (io_port == OFS_MALL)
      rdata_nxt = {{(8-NCH){1'b0}}, mask_o};
    else
      rdata_nxt = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      io_rdata <= 8'h00;
    else if (bus_rd) io_rdata <= rdata_nxt;
  end

  AST_RESET_MASK: assert property (@(posedge clk)
    !rst_n |=> mask_o == '1 && cmd_o == 8'h00 && req_o == '0); // R1
  AST_CTRL_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !is_ch && io_port != OFS_CMD && io_port != OFS_MALL |=> io_rdata == 8'h00); // R9
endmodule

// File: tb/dma4_regfile_test.sv
module dma4_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0]  io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  prog_load = '0;
  logic [15:0] prog_value = '0;
  logic [3:0]  tc_hit = '0;
  logic [3:0]  mask_o, req_o;
  logic [7:0]  cmd_o;
  logic [31:0] mode_o;
  logic [63:0] cur_addr_o, base_cnt_o;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dma4_regfile uut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .prog_load(prog_load), .prog_value(prog_value), .tc_hit(tc_hit),
    .mask_o(mask_o), .req_o(req_o), .cmd_o(cmd_o), .mode_o(mode_o),
    .cur_addr_o(cur_addr_o), .base_cnt_o(base_cnt_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p, output logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_rd = 1'b1; io_port = p;
    @(negedge clk);
    io_sel = 1'b0; io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rd_pair(input string tag, input logic [3:0] p, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd(p, lo);
    rd(p, hi);
    check(tag, {hi, lo}, exp);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] p, input logic [7:0] exp);
    logic [7:0] d;
    rd(p, d);
    check(tag, d, exp);
  endtask

  task automatic pulse_prog(input logic [3:0] ch, input logic [15:0] v);
    @(negedge clk);
    prog_load = ch; prog_value = v;
    @(negedge clk);
    prog_load = '0;
  endtask

  task automatic pulse_tc(input logic [3:0] t);
    @(negedge clk);
    tc_hit = t;
    @(negedge clk);
    tc_hit = '0;
  endtask

  task automatic t_reset;
    check("R1 mask after reset", mask_o, 4'hF);
    check("R1 cmd after reset", cmd_o, 8'h00);
    rd_chk("R1 status after reset", 4'd8, 8'h00);
    rd_pair("R1 ch0 address zero", 4'd0, 16'h0000);
  endtask

  task automatic t_pointer;
    wr(4'd0, 8'h34); wr(4'd0, 8'h12);
    wr(4'd3, 8'h10); wr(4'd3, 8'h00);
    wr(4'd2, 8'hAA);
    wr(4'd12, 8'h00);
    wr(4'd2, 8'hBB); wr(4'd2, 8'hCC);
    rd_pair("R2 R3 ch0 address", 4'd0, 16'h1234);
    rd_pair("R2 ch1 address after pointer clear", 4'd2, 16'hCCBB);
    rd_pair("R3 ch1 count", 4'd3, 16'h0010);
    check("R3 ch1 current address", cur_addr_o[31:16], 16'hCCBB);
    check("R3 ch1 base count", base_cnt_o[31:16], 16'h0010);
  endtask

  task automatic t_progress;
    pulse_prog(4'b0010, 16'd3);
    rd_pair("R4 R11 count minus progress", 4'd3, 16'h000D);
    rd_pair("R4 address plus progress", 4'd2, 16'hCCBE);
    wr(4'd11, 8'h21);
    check("R7 mode ch1", mode_o[15:8], 8'h21);
    rd_pair("R4 address minus progress", 4'd2, 16'hCCB8);
    pulse_prog(4'b0010, 16'h0020);
    rd_pair("R4 count wraps", 4'd3, 16'hFFF0);
    rd_pair("R4 address decrement 0x20", 4'd2, 16'hCC9B);
    // same-cycle progress load and high-byte write on ch1
    wr(4'd3, 8'h20);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_port = 4'd3; io_wdata = 8'h00;
    prog_load = 4'b0010; prog_value = 16'd5;
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b0; prog_load = '0;
    rd_pair("R11 reload wins over load", 4'd3, 16'h0020);
    rd_pair("R3 R11 address reloaded", 4'd2, 16'hCCBB);
  endtask

  task automatic t_command;
    wr(4'd8, 8'h04); check("R5 accept bit2", cmd_o, 8'h04);
    wr(4'd8, 8'h01); check("R5 reject bit0", cmd_o, 8'h04);
    wr(4'd8, 8'h00); check("R5 accept zero", cmd_o, 8'h00);
    wr(4'd8, 8'h84); check("R5 reject 0x84", cmd_o, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    pulse_tc(4'b0100);
    rd_chk("R10 tc2 set", 4'd8, 8'h04);
    rd_chk("R9 status read clears tc", 4'd8, 8'h00);
    wr(4'd9, 8'h06);
    rd_chk("R6 request ch2 set", 4'd8, 8'h40);
    check("R6 req_o", req_o, 4'b0100);
    pulse_tc(4'b0010);
    wr(4'd9, 8'h01);
    rd_chk("R6 request write clears tc1", 4'd8, 8'h40);
    @(negedge clk);
    io_sel = 1'b1; io_rd = 1'b1; io_port = 4'd8; tc_hit = 4'b1000;
    @(negedge clk);
    io_sel = 1'b0; io_rd = 1'b0; tc_hit = '0;
    d = io_rdata;
    check("R9 read returns old status", d, 8'h40);
    rd_chk("R10 tc kept over read-clear", 4'd8, 8'h48);
    rd_chk("R9 cleared after read", 4'd8, 8'h40);
    wr(4'd9, 8'h02);
    check("R6 request ch2 cleared", req_o, 4'b0000);
  endtask

  task automatic t_mask;
    wr(4'd14, 8'h00); check("R7 clear all", mask_o, 4'h0);
    wr(4'd10, 8'h05); check("R7 set ch1", mask_o, 4'b0010);
    wr(4'd10, 8'h07); check("R7 set ch3", mask_o, 4'b1010);
    wr(4'd10, 8'h01); check("R7 clear ch1", mask_o, 4'b1000);
    wr(4'd15, 8'h06); check("R7 write all", mask_o, 4'b0110);
    rd_chk("R9 mask read", 4'd15, 8'h06);
    rd_chk("R9 other control read zero", 4'd9, 8'h00);
    rd_chk("R9 offset 12 read zero", 4'd12, 8'h00);
  endtask

  task automatic t_master;
    wr(4'd8, 8'h04); wr(4'd14, 8'h00);
    pulse_tc(4'b0001); wr(4'd9, 8'h07);
    wr(4'd0, 8'h11);
    wr(4'd13, 8'h00);
    check("R8 mask set", mask_o, 4'hF);
    check("R8 cmd cleared", cmd_o, 8'h00);
    check("R8 req cleared", req_o, 4'h0);
    rd_chk("R8 status cleared", 4'd8, 8'h00);
    wr(4'd0, 8'h55); wr(4'd0, 8'h66);
    rd_pair("R8 pointer cleared", 4'd0, 16'h6655);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pointer();
    t_progress();
    t_command();
    t_status();
    t_mask();
    t_master();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule